// File: doc/BRIEF.md
# Video pixel input format demultiplexer

This block sits at the pixel entry point of a video encoder. Each 24-bit pixel word arrives on a valid/ready input stream. A line-active level marks the span of a line that carries picture data. A six-bit format setting tells the block how to read each word: as RGB or GBR 4:4:4, as YCbCr 4:4:4, as YCbCr 4:2:2 in one of two bus layouts, as 15-bit packed colour, or as a colour index. The block produces one canonical pixel per output transfer, with three components and a kind code, on a valid/ready output stream.

From the same setting it drives three static enable levels for later stages: the 4:2:2-to-4:4:4 interpolator, the colour lookup table and the RGB-to-colour-difference matrix. It also drives an error level for illegal settings. For 4:2:2 data it counts odd and even pixels from the first accepted word after line-active goes high. Each luma sample is then paired with the Cb/Cr pair that it shares with its neighbour.

Back-pressure works like this. An output word stays valid and unchanged until `out_ready` is high. The input is ready only when the output register is empty or draining in that cycle, and no second pixel of a 4:2:2 pair is waiting. A word is consumed on a clock edge where `in_valid` and `in_ready` are both high.

Top module: `vid_fmt_demux`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: The component order is set by `fmt_reg[3:2]` (00 = RGB, 10 = GBR). With mode `fmt_reg[1:0]`=00 and table-use bit `fmt_reg[4]`=0, a word is emitted as kind 0 (RGB). The output is c0=R, c1=G, c2=B. For RGB order these are bits 23:16, 15:8 and 7:0. For GBR order the bus holds G in 23:16, B in 15:8 and R in 7:0. The output appears in the cycle after acceptance.
- R3: With mode 00 and `fmt_reg[4]`=1, a word is emitted unchanged as kind 2 (YCbCr 4:4:4): c0=Y, c1=Cb, c2=Cr. `en_clut` is then high and `en_matrix` is low.
- R4: `en_interp` is high only for mode 01 (4:2:2) with a legal order.
- R5: `en_matrix` is high for the RGB, GBR, 15-bit and colour-index kinds. It is low for the YCbCr kinds. `en_clut` is high for the YCbCr kinds and for colour index.
- R6: Order 01 or 11 raises `fmt_err` and forces all three enables low. Words accepted while the error is raised give no output.
- R7: With mode 01 and layout bit `fmt_reg[5]`=1, each word carries Y in 23:16, Cb in 15:8 and Cr in 7:0. It is emitted as kind 3 in the cycle after acceptance.
- R8: With mode 01 and `fmt_reg[5]`=0, each word carries Y in 23:16 and one chroma byte in 15:8. The byte is Cb on odd pixels and Cr on even pixels, and the first word after line-active rises is pixel 1. An odd word gives no output. The even word that follows releases two kind-3 pixels, the odd Y then the even Y, and both carry the odd word's Cb and the even word's Cr.
- R9: While `line_act` is low, accepted words give no output and the odd/even phase returns to odd. A held odd pixel is then discarded.
- R10: Mode 10 reads a 5-5-5 field in bits 14:0. For RGB order R is in 14:10, G in 9:5 and B in 4:0; for GBR order G, B and R are in those fields. Each field widens to 8 bits as {f, f[4:2]}, and the pixel is emitted as kind 1 with c0=R, c1=G, c2=B.
- R11: Mode 11 emits kind 4 with c0 = bits 7:0 (the index) and c1=c2=0.
- R12: While `out_valid` is high and `out_ready` is low, the output components stay unchanged and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fmt_reg | input | 6 | Format setting: [5] 4:2:2 layout, [4] table use, [3:2] order, [1:0] mode |
| line_act | input | 1 | High while a line's active data is presented |
| in_valid | input | 1 | Input word valid (load strobe) |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 24 | Pixel word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_kind | output | 3 | 0 RGB, 1 15-bit, 2 YCbCr 4:4:4, 3 YCbCr 4:2:2, 4 index, 7 none |
| out_c0 | output | 8 | R, Y or index |
| out_c1 | output | 8 | G or Cb |
| out_c2 | output | 8 | B or Cr |
| en_interp | output | 1 | Interpolator enable |
| en_clut | output | 1 | Lookup table enable |
| en_matrix | output | 1 | Matrix enable |
| fmt_err | output | 1 | Illegal order code |

## Verification
Two things can happen in the same clock edge: the output handing over a pixel, and the intake taking a new word. The first test holds `out_ready` low with a word already in the output register and a second word offered. `in_ready` must stay low and the held pixel must not change. Then `out_ready` is raised, and on one edge the old pixel must leave and the new one must enter, with neither lost nor emitted twice. With the narrow 4:2:2 layout a second case arises: the release of the waiting even pixel coincides with the next odd word being offered. The bench judges this from the captured output sequence of Y, Cb and Cr values.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef enum logic [2:0] {
    PK_RGB    = 3'd0,
    PK_RGB15  = 3'd1,
    PK_YCC444 = 3'd2,
    PK_YCC422 = 3'd3,
    PK_CI     = 3'd4,
    PK_NONE   = 3'd7
  } pix_kind_e;

  localparam logic [1:0] ORD_RGB  = 2'b00;
  localparam logic [1:0] ORD_GBR  = 2'b10;
  localparam logic [1:0] MODE_444 = 2'b00;
  localparam logic [1:0] MODE_422 = 2'b01;
  localparam logic [1:0] MODE_15  = 2'b10;
  localparam logic [1:0] MODE_CI  = 2'b11;
endpackage

// File: rtl/vfd_decode.sv
module vfd_decode
  import vfd_pkg::*;
(
  input  logic [5:0] fmt,
  output pix_kind_e  kind,
  output logic       gbr,
  output logic       narrow,
  output logic       err,
  output logic       en_interp,
  output logic       en_clut,
  output logic       en_matrix
);
  logic [1:0] order;
  logic [1:0] mode;
  logic       use_tab;
  logic       wide;

  assign order   = fmt[3:2];
  assign mode    = fmt[1:0];
  assign use_tab = fmt[4];
  assign wide    = fmt[5];

  always_comb begin
    err = (order != ORD_RGB) && (order != ORD_GBR);
    gbr = (order == ORD_GBR);
    unique case (mode)
      MODE_444: kind = use_tab ? PK_YCC444 : PK_RGB;
      MODE_422: kind = PK_YCC422;
      MODE_15:  kind = PK_RGB15;
      default:  kind = PK_CI;
    endcase
    if (err) kind = PK_NONE;
  end

  assign narrow    = (mode == MODE_422) && !wide;
  assign en_interp = !err && (mode == MODE_422);
  assign en_clut   = (kind == PK_YCC444) || (kind == PK_YCC422) || (kind == PK_CI);
  assign en_matrix = (kind == PK_RGB) || (kind == PK_RGB15) || (kind == PK_CI);
endmodule

// File: rtl/vfd_unpack.sv
module vfd_unpack
  import vfd_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 5
) (
  input  logic [3*CW-1:0] word,
  input  pix_kind_e       kind,
  input  logic            gbr,
  output logic [CW-1:0]   c0,
  output logic [CW-1:0]   c1,
  output logic [CW-1:0]   c2
);
  localparam int XW = CW - PW;

  function automatic logic [CW-1:0] widen(input logic [PW-1:0] f);
    return {f, f[PW-1 -: XW]};
  endfunction

  logic [CW-1:0] hi, mid, lo;
  logic [PW-1:0] f_hi, f_mid, f_lo;

  assign hi    = word[3*CW-1 -: CW];
  assign mid   = word[2*CW-1 -: CW];
  assign lo    = word[CW-1:0];
  assign f_hi  = word[3*PW-1 -: PW];
  assign f_mid = word[2*PW-1 -: PW];
  assign f_lo  = word[PW-1:0];

  always_comb begin
    c0 = '0;
    c1 = '0;
    c2 = '0;
    unique case (kind)
      PK_RGB: begin
        if (gbr) begin
          c0 = lo;  c1 = hi;  c2 = mid;
        end else begin
          c0 = hi;  c1 = mid; c2 = lo;
        end
      end
      PK_RGB15: begin
        if (gbr) begin
          c0 = widen(f_lo);  c1 = widen(f_hi);  c2 = widen(f_mid);
        end else begin
          c0 = widen(f_hi);  c1 = widen(f_mid); c2 = widen(f_lo);
        end
      end
      PK_YCC444, PK_YCC422: begin
        c0 = hi;  c1 = mid;  c2 = lo;
      end
      PK_CI: begin
        c0 = lo;
      end
      default: begin
        c0 = '0;
      end
    endcase
  end
endmodule

// File: rtl/vfd_pair.sv
module vfd_pair
  import vfd_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          line_act,
  input  logic          err,
  input  logic          narrow,
  input  pix_kind_e     kind,
  input  logic [CW-1:0] c0,
  input  logic [CW-1:0] c1,
  input  logic [CW-1:0] c2,
  input  logic          out_ready,
  output logic          o_valid,
  output logic          p_valid,
  output pix_kind_e     o_kind,
  output logic [CW-1:0] o_c0,
  output logic [CW-1:0] o_c1,
  output logic [CW-1:0] o_c2
);
  logic          expect_odd;
  logic [CW-1:0] hold_y, hold_cb;
  logic [CW-1:0] p_y, p_cb, p_cr;
  logic          fire, live, take_odd, take_even, take_one;

  assign fire      = o_valid && out_ready;
  assign live      = take && line_act && !err;
  assign take_odd  = live && narrow && expect_odd;
  assign take_even = live && narrow && !expect_odd;
  assign take_one  = live && !narrow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expect_odd <= 1'b1;
      hold_y     <= '0;
      hold_cb    <= '0;
      p_y        <= '0;
      p_cb       <= '0;
      p_cr       <= '0;
      p_valid    <= 1'b0;
      o_valid    <= 1'b0;
      o_kind     <= PK_NONE;
      o_c0       <= '0;
      o_c1       <= '0;
      o_c2       <= '0;
    end else begin
      if (take_odd) begin
        hold_y     <= c0;
        hold_cb    <= c1;
        expect_odd <= 1'b0;
        if (fire) o_valid <= 1'b0;
      end else if (take_even) begin
        o_c0       <= hold_y;
        o_c1       <= hold_cb;
        o_c2       <= c1;
        o_kind     <= PK_YCC422;
        o_valid    <= 1'b1;
        p_y        <= c0;
        p_cb       <= hold_cb;
        p_cr       <= c1;
        p_valid    <= 1'b1;
        expect_odd <= 1'b1;
      end else if (take_one) begin
        o_c0    <= c0;
        o_c1    <= c1;
        o_c2    <= c2;
        o_kind  <= kind;
        o_valid <= 1'b1;
      end else if (fire) begin
        if (p_valid) begin
          o_c0    <= p_y;
          o_c1    <= p_cb;
          o_c2    <= p_cr;
          o_kind  <= PK_YCC422;
          p_valid <= 1'b0;
        end else begin
          o_valid <= 1'b0;
        end
      end
      if (!line_act) expect_odd <= 1'b1;
    end
  end
endmodule

// File: rtl/vid_fmt_demux.sv
module vid_fmt_demux
  import vfd_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      fmt_reg,
  input  logic            line_act,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3*CW-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_kind,
  output logic [CW-1:0]   out_c0,
  output logic [CW-1:0]   out_c1,
  output logic [CW-1:0]   out_c2,
  output logic            en_interp,
  output logic            en_clut,
  output logic            en_matrix,
  output logic            fmt_err
);
  pix_kind_e     dec_kind, o_kind;
  logic          gbr, narrow, p_valid;
  logic [CW-1:0] u_c0, u_c1, u_c2;

  vfd_decode u_dec (
    .fmt       (fmt_reg),
    .kind      (dec_kind),
    .gbr       (gbr),
    .narrow    (narrow),
    .err       (fmt_err),
    .en_interp (en_interp),
    .en_clut   (en_clut),
    .en_matrix (en_matrix)
  );

  vfd_unpack #(.CW(CW), .PW(PW)) u_unp (
    .word (in_data),
    .kind (dec_kind),
    .gbr  (gbr),
    .c0   (u_c0),
    .c1   (u_c1),
    .c2   (u_c2)
  );

  assign in_ready = !p_valid && (!out_valid || out_ready);

  vfd_pair #(.CW(CW)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid && in_ready),
    .line_act  (line_act),
    .err       (fmt_err),
    .narrow    (narrow),
    .kind      (dec_kind),
    .c0        (u_c0),
    .c1        (u_c1),
    .c2        (u_c2),
    .out_ready (out_ready),
    .o_valid   (out_valid),
    .p_valid   (p_valid),
    .o_kind    (o_kind),
    .o_c0      (out_c0),
    .o_c1      (out_c1),
    .o_c2      (out_c2)
  );

  assign out_kind = o_kind;
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    fmt_reg,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_c0,
  input logic [CW-1:0] out_c1,
  input logic [CW-1:0] out_c2,
  input logic          en_interp,
  input logic          en_clut,
  input logic          en_matrix,
  input logic          fmt_err
);
  p_hold_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_c0) && $stable(out_c1) && $stable(out_c2));

  p_stall_no_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_interp_422_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en_interp |-> fmt_reg[1:0] == 2'b01);

  p_matrix_off_ycc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_reg[1:0] == 2'b01 |-> !en_matrix);

  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> !en_interp && !en_clut && !en_matrix);
endmodule

bind vid_fmt_demux vfd_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_reg   (fmt_reg),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_c0    (out_c0),
  .out_c1    (out_c1),
  .out_c2    (out_c2),
  .en_interp (en_interp),
  .en_clut   (en_clut),
  .en_matrix (en_matrix),
  .fmt_err   (fmt_err)
);

// File: tb/vid_fmt_demux_tb.sv
module vid_fmt_demux_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {fmt, word, en{interp,clut,matrix,err}, has_out, kind, expected c0c1c2}
  localparam logic [61:0] VEC [NV] = '{
    {6'h00, 24'h112233, 4'b0010, 1'b1, 3'd0, 24'h112233},  // R2 RGB
    {6'h08, 24'h112233, 4'b0010, 1'b1, 3'd0, 24'h331122},  // R2 GBR
    {6'h10, 24'h112233, 4'b0100, 1'b1, 3'd2, 24'h112233},  // R3
    {6'h18, 24'h445566, 4'b0100, 1'b1, 3'd2, 24'h445566},  // R3
    {6'h02, 24'h004321, 4'b0010, 1'b1, 3'd1, 24'h84CE08},  // R10 RGB15
    {6'h0A, 24'h004321, 4'b0010, 1'b1, 3'd1, 24'h0884CE},  // R10 GBR15
    {6'h03, 24'hAABB5C, 4'b0110, 1'b1, 3'd4, 24'h5C0000},  // R11
    {6'h04, 24'h123456, 4'b0001, 1'b0, 3'd7, 24'h000000},  // R6 order 01
    {6'h0C, 24'h123456, 4'b0001, 1'b0, 3'd7, 24'h000000},  // R6 order 11
    {6'h21, 24'h102030, 4'b1100, 1'b1, 3'd3, 24'h102030}   // R7 wide 4:2:2
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] fmt_reg = '0;
  logic line_act = 1'b0, in_valid = 1'b0, out_ready = 1'b1;
  logic [23:0] in_data = '0;
  logic in_ready, out_valid, en_interp, en_clut, en_matrix, fmt_err;
  logic [2:0] out_kind;
  logic [7:0] out_c0, out_c1, out_c2;

  int checks = 0, errors = 0, ncap = 0;
  logic [26:0] cap [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_fmt_demux u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_reg(fmt_reg), .line_act(line_act),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
    .en_interp(en_interp), .en_clut(en_clut), .en_matrix(en_matrix),
    .fmt_err(fmt_err)
  );

  always @(negedge clk)
    if (rst_n && out_valid && out_ready && ncap < 64) begin
      cap[ncap] = {out_kind, out_c0, out_c1, out_c2};
      ncap = ncap + 1;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [23:0] w);
    logic ok;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = w;
    do begin
      @(negedge clk);
      ok = in_ready;
      @(posedge clk); #1;
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    line_act = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [61:0] v;
      v = VEC[i];
      fmt_reg = v[61:56];
      base = ncap;
      send(v[55:32]);
      settle();
      chk("R4 R5 R6 enables", {28'd0, en_interp, en_clut, en_matrix, fmt_err}, {28'd0, v[31:28]});
      chk("R2 R3 R6 R7 R10 R11 count", ncap - base, {31'd0, v[27]});
      if (v[27] && ncap > base)
        chk("R2 R3 R7 R10 R11 pixel", {5'd0, cap[base]}, {5'd0, v[26:0]});
    end

    // R8 narrow 4:2:2 pairing
    fmt_reg = 6'h01;
    line_act = 1'b0; settle(); line_act = 1'b1;
    base = ncap;
    send(24'h11A099);
    settle();
    chk("R8 odd alone gives nothing", ncap - base, 0);
    send(24'h22B088);
    send(24'h33C077);
    send(24'h44D066);
    settle();
    chk("R8 count", ncap - base, 4);
    chk("R8 pix1", {5'd0, cap[base]},   {5'd0, 3'd3, 24'h11A0B0});
    chk("R8 pix2", {5'd0, cap[base+1]}, {5'd0, 3'd3, 24'h22A0B0});
    chk("R8 pix3", {5'd0, cap[base+2]}, {5'd0, 3'd3, 24'h33C0D0});
    chk("R8 pix4", {5'd0, cap[base+3]}, {5'd0, 3'd3, 24'h44D0D0 & 24'hFFC0D0 | 24'h440000});

    // R9 phase reset on line_act low
    base = ncap;
    send(24'h55E000);
    @(posedge clk); #1; line_act = 1'b0;
    send(24'h99F100);
    settle();
    chk("R9 no output while low", ncap - base, 0);
    line_act = 1'b1;
    send(24'h66F000);
    send(24'h770700);
    settle();
    chk("R9 count", ncap - base, 2);
    chk("R9 pix1", {5'd0, cap[base]},   {5'd0, 3'd3, 24'h66F007});
    chk("R9 pix2", {5'd0, cap[base+1]}, {5'd0, 3'd3, 24'h77F007});

    // R12 back-pressure with simultaneous drain and take
    fmt_reg = 6'h00;
    out_ready = 1'b0;
    base = ncap;
    send(24'hA1A2A3);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = 24'hB1B2B3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 in_ready low", {31'd0, in_ready}, 32'd0);
      chk("R12 held pixel", {8'd0, out_c0, out_c1, out_c2}, 32'h00A1A2A3);
    end
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    settle();
    chk("R12 count", ncap - base, 2);
    chk("R12 first", {8'd0, cap[base][23:0]}, 32'h00A1A2A3);
    chk("R12 second", {8'd0, cap[base+1][23:0]}, 32'h00B1B2B3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule